// File: doc/BRIEF.md
# 4:2:2 Chroma Resampling Filter

This block sits in a video capture path. It takes a YCbCr 4:2:2 sample stream in which each chroma sample shares its position with a luma sample, and moves every chroma sample half a pixel to the right, so that it lies midway between two luma samples. Each new Cb or Cr value is a weighted sum of four samples of the same component: one before, the current one and two after. The weights are -3, 101, 33 and -3. The sum is rounded and divided by 128, then clipped to the sample range. Luma goes through untouched, with the same delay as the chroma path, so the component order of the stream is kept.

A sample enters on every cycle with `in_valid` high. Each sample carries a component tag and markers for the first and last sample of a line. Inside a line the order is Cb, Y, Cr, Y, repeated, and there are no idle cycles. Between lines any number of idle cycles is allowed, including none. At the edges of a line, neighbours that would fall outside it are replaced with copies of the nearest sample of that component inside the line. No line-length setting is needed, because the markers define the edges. The output stream has the same format as the input and follows it at a fixed delay.

Top module: `chroma_resampler`

## Requirements
- R1: An output Cb or Cr sample equals clip(floor((-3*p + 101*c + 33*n1 - 3*n2 + 64) / 128)). Here c is the matching input sample, p is the previous sample of the same component, and n1 and n2 are the next two samples of the same component. All of them are taken as unsigned 8-bit values.
- R2: The tag values are 0 for Y, 1 for Cb and 2 for Cr. Within a line, samples of the same component are 4 positions apart. Cb and Cr are filtered separately, with the same weights, and each uses only samples of its own component.
- R3: For the first chroma sample of each component in a line, p is replaced by that sample itself.
- R4: When n1 or n2 would lie beyond the last sample of the line, each missing one is replaced by the last sample of that component in the line.
- R5: A sample tagged Y leaves with its data value unchanged.
- R6: A chroma result below 0 is output as 0, and a result above 255 is output as 255.
- R7: A sample captured on clock edge t appears at the outputs after edge t+9. Its tag, line-start marker and line-end marker are unchanged, and the output order is the input order.
- R8: While reset is held, and until the first sample has passed through, `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input sample is present this cycle |
| in_data | input | 8 | Input sample value |
| in_tag | input | 2 | Component of the input sample (0 Y, 1 Cb, 2 Cr) |
| in_sol | input | 1 | Input sample is the first of its line |
| in_eol | input | 1 | Input sample is the last of its line |
| out_valid | output | 1 | An output sample is present this cycle |
| out_data | output | 8 | Output sample value |
| out_tag | output | 2 | Component of the output sample |
| out_sol | output | 1 | Output sample is the first of its line |
| out_eol | output | 1 | Output sample is the last of its line |

## Verification
The bench sends lines of 4 samples, which hold a single chroma sample of each kind, and also very short lines, so that leading and trailing replication apply to the same sample. A design that took neighbours across a line edge would produce values that depend on the previous or next line. Lines are sent back to back with no idle cycle between them. This exposes a design that relies on idle cycles to separate lines, or that mixes up Cb and Cr by taking neighbours at the wrong distance. Chroma patterns that push the sum below 0 and above 255 catch results that wrap instead of clipping. Flat lines catch a rounding offset that is off by one.

// File: rtl/chroma_rs_pkg.sv
package chroma_rs_pkg;

   // Component tag carried with every sample.
   typedef enum logic [1:0] {
      TAG_Y   = 2'd0,
      TAG_CB  = 2'd1,
      TAG_CR  = 2'd2,
      TAG_RSV = 2'd3
   } tag_e;

   // Distance between two samples of one chroma component in a 4:2:2 line.
   localparam int SPAN   = 4;
   // Window slot of the sample being filtered (slot 0 is the newest).
   localparam int CENTER = 2 * SPAN;
   // Slots needed: two same-component neighbours ahead, one behind.
   localparam int WIN    = 3 * SPAN + 1;
   // Edges from capture to the output register update.
   localparam int LAT    = CENTER + 1;

   // Per-sample side information, moved along with the data.
   typedef struct packed {
      logic valid;
      tag_e tag;
      logic sol;
      logic eol;
   } meta_t;

endpackage

// File: rtl/chroma_rs_window.sv
module chroma_rs_window
   import chroma_rs_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  meta_t         in_meta,
   input  logic [DW-1:0] in_data,
   output meta_t         win_meta [WIN],
   output logic [DW-1:0] win_data [WIN]
);

   // Shift register: slot 0 is the newest sample, slot WIN-1 the oldest.
   // It advances on every clock cycle, so distance in slots equals distance
   // in stream positions inside a gap-free line.
   for (genvar g = 0; g < WIN; g++) begin : g_slot
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_meta[g] <= '0;
               win_data[g] <= '0;
            end else begin
               win_meta[g] <= in_meta;
               win_data[g] <= in_data;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_meta[g] <= '0;
               win_data[g] <= '0;
            end else begin
               win_meta[g] <= win_meta[g-1];
               win_data[g] <= win_data[g-1];
            end
         end
      end
   end

endmodule

// File: rtl/chroma_rs_taps.sv
module chroma_rs_taps
   import chroma_rs_pkg::*;
#(
   parameter int DW = 8
) (
   input  meta_t         win_meta [WIN],
   input  logic [DW-1:0] win_data [WIN],
   output logic [DW-1:0] tap_prev,
   output logic [DW-1:0] tap_cur,
   output logic [DW-1:0] tap_next1,
   output logic [DW-1:0] tap_next2
);

   localparam int PREV_SLOT  = CENTER + SPAN;
   localparam int NEXT1_SLOT = CENTER - SPAN;
   localparam int NEXT2_SLOT = CENTER - 2 * SPAN;

   logic cut_prev;   // line start between previous neighbour and center
   logic cut_next1;  // line end before the first forward neighbour
   logic cut_next2;  // line end before the second forward neighbour

   always_comb begin
      cut_prev = 1'b0;
      for (int i = CENTER; i < PREV_SLOT; i++) begin
         cut_prev = cut_prev | (win_meta[i].valid & win_meta[i].sol);
      end
   end

   always_comb begin
      cut_next1 = 1'b0;
      for (int i = NEXT1_SLOT + 1; i <= CENTER; i++) begin
         cut_next1 = cut_next1 | (win_meta[i].valid & win_meta[i].eol);
      end
   end

   always_comb begin
      cut_next2 = 1'b0;
      for (int i = NEXT2_SLOT + 1; i <= CENTER; i++) begin
         cut_next2 = cut_next2 | (win_meta[i].valid & win_meta[i].eol);
      end
   end

   // Edge replication: a missing neighbour takes the nearest in-line value.
   always_comb begin
      tap_cur   = win_data[CENTER];
      tap_prev  = cut_prev  ? win_data[CENTER] : win_data[PREV_SLOT];
      tap_next1 = cut_next1 ? win_data[CENTER] : win_data[NEXT1_SLOT];
      if (cut_next1)
         tap_next2 = win_data[CENTER];
      else if (cut_next2)
         tap_next2 = win_data[NEXT1_SLOT];
      else
         tap_next2 = win_data[NEXT2_SLOT];
   end

endmodule

// File: rtl/chroma_rs_mac.sv
module chroma_rs_mac #(
   parameter int DW      = 8,
   parameter int SHIFT   = 7,
   parameter int W_PREV  = -3,
   parameter int W_CUR   = 101,
   parameter int W_NEXT1 = 33,
   parameter int W_NEXT2 = -3,
   parameter bit ROUND   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] tap_prev,
   input  logic [DW-1:0] tap_cur,
   input  logic [DW-1:0] tap_next1,
   input  logic [DW-1:0] tap_next2,
   output logic [DW-1:0] res_q
);

   localparam int ACC_W = DW + SHIFT + 4;

   if (W_PREV + W_CUR + W_NEXT1 + W_NEXT2 != (1 << SHIFT)) begin : g_gain_chk
      $error("chroma_rs_mac: weights must sum to 2**SHIFT for unity gain");
   end
   if (SHIFT < 1 || DW < 2) begin : g_width_chk
      $error("chroma_rs_mac: SHIFT and DW out of range");
   end

   localparam logic signed [ACC_W-1:0] K_PREV  = ACC_W'(W_PREV);
   localparam logic signed [ACC_W-1:0] K_CUR   = ACC_W'(W_CUR);
   localparam logic signed [ACC_W-1:0] K_NEXT1 = ACC_W'(W_NEXT1);
   localparam logic signed [ACC_W-1:0] K_NEXT2 = ACC_W'(W_NEXT2);
   localparam logic signed [ACC_W-1:0] MAXV    = ACC_W'((1 << DW) - 1);

   logic signed [ACC_W-1:0] bias;
   if (ROUND) begin : g_round
      assign bias = ACC_W'(1 << (SHIFT - 1));
   end else begin : g_trunc
      assign bias = '0;
   end

   logic signed [ACC_W-1:0] x_prev, x_cur, x_next1, x_next2;
   logic signed [ACC_W-1:0] acc, quo;
   logic [DW-1:0]           sat;

   always_comb begin
      x_prev  = $signed({{(ACC_W-DW){1'b0}}, tap_prev});
      x_cur   = $signed({{(ACC_W-DW){1'b0}}, tap_cur});
      x_next1 = $signed({{(ACC_W-DW){1'b0}}, tap_next1});
      x_next2 = $signed({{(ACC_W-DW){1'b0}}, tap_next2});
      acc = K_PREV * x_prev + K_CUR * x_cur + K_NEXT1 * x_next1
          + K_NEXT2 * x_next2 + bias;
      quo = acc >>> SHIFT;
      if (quo < 0)
         sat = '0;
      else if (quo > MAXV)
         sat = MAXV[DW-1:0];
      else
         sat = quo[DW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q <= '0;
      else        res_q <= sat;
   end

   // R1: unity gain, a flat neighbourhood comes out unchanged
   a_r1_flat_gain: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(tap_prev == tap_cur) && $past(tap_next1 == tap_cur)
       && $past(tap_next2 == tap_cur)) |-> (res_q == $past(tap_cur)));

endmodule

// File: rtl/chroma_resampler.sv
module chroma_resampler
   import chroma_rs_pkg::*;
#(
   parameter int DW      = 8,
   parameter int SHIFT   = 7,
   parameter int W_PREV  = -3,
   parameter int W_CUR   = 101,
   parameter int W_NEXT1 = 33,
   parameter int W_NEXT2 = -3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic [1:0]    in_tag,
   input  logic          in_sol,
   input  logic          in_eol,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic [1:0]    out_tag,
   output logic          out_sol,
   output logic          out_eol
);

   localparam int AGE_W = $clog2(LAT + 3);

   if (DW < 2) begin : g_dw_chk
      $error("chroma_resampler: DW must be at least 2");
   end

   meta_t         in_meta;
   meta_t         win_meta [WIN];
   logic [DW-1:0] win_data [WIN];
   logic [DW-1:0] t_prev, t_cur, t_next1, t_next2;
   logic [DW-1:0] chroma_q;
   logic [DW-1:0] pass_q;
   meta_t         meta_q;
   logic          is_chroma_q;

   always_comb begin
      in_meta.valid = in_valid;
      in_meta.tag   = tag_e'(in_tag);
      in_meta.sol   = in_sol;
      in_meta.eol   = in_eol;
   end

   chroma_rs_window #(.DW(DW)) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_meta  (in_meta),
      .in_data  (in_data),
      .win_meta (win_meta),
      .win_data (win_data)
   );

   chroma_rs_taps #(.DW(DW)) u_taps (
      .win_meta  (win_meta),
      .win_data  (win_data),
      .tap_prev  (t_prev),
      .tap_cur   (t_cur),
      .tap_next1 (t_next1),
      .tap_next2 (t_next2)
   );

   chroma_rs_mac #(
      .DW      (DW),
      .SHIFT   (SHIFT),
      .W_PREV  (W_PREV),
      .W_CUR   (W_CUR),
      .W_NEXT1 (W_NEXT1),
      .W_NEXT2 (W_NEXT2),
      .ROUND   (1'b1)
   ) u_mac (
      .clk       (clk),
      .rst_n     (rst_n),
      .tap_prev  (t_prev),
      .tap_cur   (t_cur),
      .tap_next1 (t_next1),
      .tap_next2 (t_next2),
      .res_q     (chroma_q)
   );

   // Output stage, aligned with the multiply-accumulate register.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q      <= '0;
         pass_q      <= '0;
         is_chroma_q <= 1'b0;
      end else begin
         meta_q      <= win_meta[CENTER];
         pass_q      <= win_data[CENTER];
         is_chroma_q <= (win_meta[CENTER].tag == TAG_CB) ||
                        (win_meta[CENTER].tag == TAG_CR);
      end
   end

   assign out_valid = meta_q.valid;
   assign out_data  = is_chroma_q ? chroma_q : pass_q;
   assign out_tag   = meta_q.tag;
   assign out_sol   = meta_q.sol;
   assign out_eol   = meta_q.eol;

   // Edges since reset, saturating; guards properties that look back LAT+1.
   logic [AGE_W-1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       age_q <= '0;
      else if (age_q != AGE_W'(LAT + 2)) age_q <= age_q + 1'b1;
   end

   // R5: luma data leaves unchanged after the fixed delay
   a_r5_luma_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == AGE_W'(LAT + 2) && out_valid && out_tag == 2'd0)
      |-> (out_data == $past(in_data, LAT + 1)));

   // R7: valid and tag follow the input after the fixed delay
   a_r7_order: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == AGE_W'(LAT + 2)) |->
      (out_valid == $past(in_valid, LAT + 1)) &&
      (!out_valid || out_tag == $past(in_tag, LAT + 1)));

   // R7: line markers follow the input after the fixed delay
   a_r7_markers: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == AGE_W'(LAT + 2) && out_valid) |->
      (out_sol == $past(in_sol, LAT + 1)) && (out_eol == $past(in_eol, LAT + 1)));

   // R8: nothing leaves the block until the pipeline has filled
   a_r8_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q < AGE_W'(LAT)) |-> !out_valid);

endmodule

// File: tb/chroma_resampler_bench.sv
module chroma_resampler_bench;

   localparam int CLK_PERIOD = 10;
   localparam int LAT_EDGES  = 9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic [1:0] in_tag = '0;
   logic       in_sol = 1'b0;
   logic       in_eol = 1'b0;
   logic       out_valid;
   logic [7:0] out_data;
   logic [1:0] out_tag;
   logic       out_sol;
   logic       out_eol;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0] d;
      logic [1:0] tag;
      logic       sol;
      logic       eol;
      int         stamp;
      int         req;
   } exp_t;

   exp_t expq[$];

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   chroma_resampler u_chroma_resampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_tag    (in_tag),
      .in_sol    (in_sol),
      .in_eol    (in_eol),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_tag   (out_tag),
      .out_sol   (out_sol),
      .out_eol   (out_eol)
   );

   function automatic string rname(input int r);
      case (r)
         1: return "R1";
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input int r, input int act, input int expv, input string what);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rname(r), what, act, expv);
      end
   endtask

   // Reference weighted sum with rounding, before clipping.
   function automatic int wsum(input int p, input int c, input int n1, input int n2);
      int s;
      s = -3 * p + 101 * c + 33 * n1 - 3 * n2 + 64;
      return s >>> 7;
   endfunction

   // mode 0 random, 1 flat, 2 saturating chroma pattern
   task automatic send_line(input int len, input int mode);
      logic [7:0] smp [0:63];
      logic [7:0] flat;
      int n;
      flat = 8'($urandom_range(0, 255));
      n = len / 4;
      for (int i = 0; i < len; i++) begin
         case (mode)
            1: smp[i] = flat;
            2: begin
               if (i % 4 == 0)      smp[i] = ((i / 4) % 4 == 0 || (i / 4) % 4 == 3) ? 8'd255 : 8'd0;
               else if (i % 4 == 2) smp[i] = ((i / 4) % 4 == 0 || (i / 4) % 4 == 3) ? 8'd0 : 8'd255;
               else                 smp[i] = 8'($urandom_range(0, 255));
            end
            default: smp[i] = 8'($urandom_range(0, 255));
         endcase
      end
      for (int i = 0; i < len; i++) begin
         exp_t e;
         int o, k, raw;
         e.tag = (i % 2 == 1) ? 2'd0 : ((i % 4 == 0) ? 2'd1 : 2'd2);
         e.sol = (i == 0);
         e.eol = (i == len - 1);
         if (e.tag == 2'd0) begin
            e.d = smp[i];
            e.req = 5;
         end else begin
            o = i % 4;
            k = i / 4;
            raw = wsum(int'(smp[4 * ((k > 0) ? k - 1 : 0) + o]),
                       int'(smp[4 * k + o]),
                       int'(smp[4 * ((k + 1 < n) ? k + 1 : n - 1) + o]),
                       int'(smp[4 * ((k + 2 < n) ? k + 2 : n - 1) + o]));
            if (raw < 0)        begin e.d = 8'd0;   e.req = 6; end
            else if (raw > 255) begin e.d = 8'd255; e.req = 6; end
            else begin
               e.d = 8'(raw);
               if (k == 0)          e.req = 3;
               else if (k >= n - 2) e.req = 4;
               else if (o == 2)     e.req = 2;
               else                 e.req = 1;
            end
         end
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = smp[i];
         in_tag   = e.tag;
         in_sol   = e.sol;
         in_eol   = e.eol;
         e.stamp  = cyc + 1;
         expq.push_back(e);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_sol   = 1'b0;
         in_eol   = 1'b0;
         in_data  = 8'($urandom_range(0, 255));
      end
   endtask

   // Output monitor, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && out_valid && !done) begin
         if (expq.size() == 0) begin
            check(7, 1, 0, "unexpected output sample");
         end else begin
            exp_t e;
            e = expq.pop_front();
            check(e.req, int'(out_data), int'(e.d), "data");
            check(7, int'(out_tag), int'(e.tag), "tag");
            check(7, int'({out_sol, out_eol}), int'({e.sol, e.eol}), "markers");
            check(7, cyc - e.stamp, LAT_EDGES, "latency");
         end
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R8: reset state
      repeat (3) @(negedge clk);
      check(8, int'(out_valid), 0, "out_valid in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(8, int'(out_valid), 0, "out_valid after reset, no input");

      // Directed corner cases
      send_line(4, 0);   // one chroma sample per component: R3 and R4 together
      idle(3);
      send_line(8, 0);
      send_line(16, 2);  // back to back, R6 saturation both ways
      send_line(12, 1);  // flat line, R1 unity gain
      idle(1);
      send_line(4, 0);
      send_line(4, 0);

      // Constrained random lines
      for (int l = 0; l < 60; l++) begin
         send_line(4 * $urandom_range(1, 12), ($urandom_range(0, 7) == 0) ? 2 : 0);
         idle($urandom_range(0, 4));
      end
      idle(LAT_EDGES + 6);
      check(7, expq.size(), 0, "samples left undelivered");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL R7 watchdog: actual=hung expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule